// File: doc/BRIEF.md
# 64-bit SECDED ECC Codec

This block protects a 64-bit memory word with an 8-bit check byte. It serves both paths of a memory controller. On the write path it turns a data word into its check byte. On the read path it takes the stored word and the stored check byte and recomputes the check byte. It XORs the two to form a syndrome, then names the failing bit.

A nonzero syndrome is matched against the 64 data columns of the fixed parity matrix. A match names a data bit, and that bit is flipped in the corrected word. When no column matches, the lowest set syndrome bit is taken as a failing check bit. A syndrome that matches no column and has more than one bit set is also reported as an uncorrectable word.

Every result is registered and appears one clock after the request. The outputs hold their last values while no request is presented.

Top module: `secded64_codec`

## Requirements
- R1: Bit i of `out_check` is the XOR of the data bits selected by 64-bit row mask i, written {high word over data[63:32], low word over data[31:0]}. The rows 0..7 are {f00fe11e,c33c0ff7}, {00ff00ff,00fff0ff}, {0f0f0f0f,0f0fff00}, {11113333,7777000f}, {22224444,8888222f}, {44448888,ffff4441}, {8888ffff,11118882}, {ffff1111,22221114}.
- R2: In read mode (`in_rd`=1), `out_syndrome` equals the computed check byte XOR `in_ecc`.
- R3: Column k of the matrix is the byte whose bit i is bit k of row mask i. When a nonzero syndrome equals column k, `out_data_err` is 1 and `out_data_idx` is k, using the lowest such k.
- R4: When the syndrome is nonzero and matches no column, `out_ecc_err` is 1 and `out_ecc_idx` is the position of the lowest set syndrome bit.
- R5: A zero syndrome raises none of `out_data_err`, `out_ecc_err` or `out_multi_err`.
- R6: `out_multi_err` is 1 exactly when the syndrome is nonzero, matches no column, and has more than one bit set.
- R7: `out_data` is `in_data` with bit `out_data_idx` inverted when `out_data_err` is 1, and equals `in_data` otherwise.
- R8: In write mode (`in_rd`=0), `out_check` is still produced. The syndrome reads 0, no error flag is raised, and `out_data` equals `in_data`.
- R9: `out_valid` equals `in_valid` of the previous clock. The other outputs take the result of a request one clock after it and hold while `in_valid` is 0.
- R10: While reset is applied, and until the second rising clock edge after `rst_n` is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_rd | input | 1 | 1 = check a read word, 0 = encode a write word |
| in_data | input | 64 | Data word |
| in_ecc | input | 8 | Received check byte (read mode) |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_check | output | 8 | Check byte computed from `in_data` |
| out_syndrome | output | 8 | Syndrome (0 in write mode) |
| out_data_err | output | 1 | Single failing data bit located |
| out_data_idx | output | 6 | Index of the failing data bit |
| out_ecc_err | output | 1 | Failing check bit assumed |
| out_ecc_idx | output | 3 | Index of the failing check bit |
| out_multi_err | output | 1 | Syndrome matches no single-bit pattern |
| out_data | output | 64 | Corrected data word |

## Verification
The hardest case to reach from the ports is a syndrome that matches no data column. Such a syndrome is either single-hot, a check-bit fault, or an uncorrectable pattern. The stimulus reaches both on purpose. It computes the correct check byte for a word, then flips one chosen check bit, or two or three bits spread across data and check. Each of the 64 data positions is also walked with a single flip. Random words with random flip counts follow, and an independent behavioural model scores every clock, including idle clocks where the outputs must hold.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(CHK_W);
  localparam int HALF_W = DATA_W / 2;

  // Parity rows: high half covers data[63:32], low half covers data[31:0]
  function automatic logic [DATA_W-1:0] row_mask(input int r);
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
    case (r)
      0:       begin hi = 32'hf00fe11e; lo = 32'hc33c0ff7; end
      1:       begin hi = 32'h00ff00ff; lo = 32'h00fff0ff; end
      2:       begin hi = 32'h0f0f0f0f; lo = 32'h0f0fff00; end
      3:       begin hi = 32'h11113333; lo = 32'h7777000f; end
      4:       begin hi = 32'h22224444; lo = 32'h8888222f; end
      5:       begin hi = 32'h44448888; lo = 32'hffff4441; end
      6:       begin hi = 32'h8888ffff; lo = 32'h11118882; end
      default: begin hi = 32'hffff1111; lo = 32'h22221114; end
    endcase
    return {hi, lo};
  endfunction

  // Syndrome produced by a fault on data bit k
  function automatic logic [CHK_W-1:0] column(input int k);
    logic [CHK_W-1:0] c;
    logic [DATA_W-1:0] m;
    for (int r = 0; r < CHK_W; r++) begin
      m    = row_mask(r);
      c[r] = m[k];
    end
    return c;
  endfunction

  typedef struct packed {
    logic              valid;
    logic [CHK_W-1:0]  chk;
    logic [CHK_W-1:0]  syn;
    logic              data_err;
    logic [IDX_W-1:0]  data_idx;
    logic              ecc_err;
    logic [CIDX_W-1:0] ecc_idx;
    logic              multi;
    logic [DATA_W-1:0] data;
  } result_t;
endpackage

// File: rtl/secded_rst_sync.sv
module secded_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_q = sr_q[STAGES-1];
endmodule

// File: rtl/secded_encode.sv
module secded_encode
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(r);
    assign chk[r] = ^(data & MASK);
  end
endmodule

// File: rtl/secded_locate.sv
module secded_locate
  import secded_pkg::*;
(
  input  logic [CHK_W-1:0]  syn,
  output logic              data_hit,
  output logic [IDX_W-1:0]  data_idx,
  output logic              ecc_hit,
  output logic [CIDX_W-1:0] ecc_idx,
  output logic              multi
);
  logic [DATA_W-1:0] match;
  logic              nonzero;
  logic              single;
  logic [CIDX_W-1:0] low_set;

  assign nonzero = |syn;
  assign single  = $onehot(syn);

  for (genvar k = 0; k < DATA_W; k++) begin : g_col
    localparam logic [CHK_W-1:0] COL = column(k);
    assign match[k] = nonzero && (syn == COL);
  end

  // lowest matching column wins
  always_comb begin
    data_hit = 1'b0;
    data_idx = '0;
    for (int k = DATA_W - 1; k >= 0; k--) begin
      if (match[k]) begin
        data_hit = 1'b1;
        data_idx = IDX_W'(k);
      end
    end
  end

  // lowest set syndrome bit
  always_comb begin
    low_set = '0;
    for (int b = CHK_W - 1; b >= 0; b--) begin
      if (syn[b]) low_set = CIDX_W'(b);
    end
  end

  assign ecc_hit = nonzero && !data_hit;
  assign ecc_idx = ecc_hit ? low_set : '0;
  assign multi   = ecc_hit && !single;
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data_out
);
  logic [DATA_W-1:0] flip;

  always_comb begin
    flip = '0;
    for (int k = 0; k < DATA_W; k++) begin
      flip[k] = hit && (idx == IDX_W'(k));
    end
  end

  assign data_out = data_in ^ flip;
endmodule

// File: rtl/secded64_codec.sv
module secded64_codec
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_rd,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHK_W-1:0]  in_ecc,
  output logic              out_valid,
  output logic [CHK_W-1:0]  out_check,
  output logic [CHK_W-1:0]  out_syndrome,
  output logic              out_data_err,
  output logic [IDX_W-1:0]  out_data_idx,
  output logic              out_ecc_err,
  output logic [CIDX_W-1:0] out_ecc_idx,
  output logic              out_multi_err,
  output logic [DATA_W-1:0] out_data
);
  logic              rst_q;
  logic [CHK_W-1:0]  chk_c;
  logic [CHK_W-1:0]  syn_c;
  logic              dhit_c;
  logic [IDX_W-1:0]  didx_c;
  logic              ehit_c;
  logic [CIDX_W-1:0] eidx_c;
  logic              multi_c;
  logic [DATA_W-1:0] fixed_c;
  result_t           res_d;
  result_t           res_q;

  secded_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  secded_encode u_enc (
    .data (in_data),
    .chk  (chk_c)
  );

  // write mode reports a clean syndrome
  assign syn_c = in_rd ? (chk_c ^ in_ecc) : '0;

  secded_locate u_loc (
    .syn      (syn_c),
    .data_hit (dhit_c),
    .data_idx (didx_c),
    .ecc_hit  (ehit_c),
    .ecc_idx  (eidx_c),
    .multi    (multi_c)
  );

  secded_fix u_fix (
    .data_in  (in_data),
    .hit      (dhit_c),
    .idx      (didx_c),
    .data_out (fixed_c)
  );

  always_comb begin
    res_d       = res_q;
    res_d.valid = in_valid;
    if (in_valid) begin
      res_d.chk      = chk_c;
      res_d.syn      = syn_c;
      res_d.data_err = dhit_c;
      res_d.data_idx = didx_c;
      res_d.ecc_err  = ehit_c;
      res_d.ecc_idx  = eidx_c;
      res_d.multi    = multi_c;
      res_d.data     = fixed_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) res_q <= '0;
    else        res_q <= res_d;
  end

  assign out_valid     = res_q.valid;
  assign out_check     = res_q.chk;
  assign out_syndrome  = res_q.syn;
  assign out_data_err  = res_q.data_err;
  assign out_data_idx  = res_q.data_idx;
  assign out_ecc_err   = res_q.ecc_err;
  assign out_ecc_idx   = res_q.ecc_idx;
  assign out_multi_err = res_q.multi;
  assign out_data      = res_q.data;
endmodule

// File: rtl/secded64_codec_chk.sv
module secded64_codec_chk
  import secded_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              in_valid,
  input logic              in_rd,
  input logic [DATA_W-1:0] in_data,
  input logic [CHK_W-1:0]  in_ecc,
  input logic              out_valid,
  input logic [CHK_W-1:0]  out_check,
  input logic [CHK_W-1:0]  out_syndrome,
  input logic              out_data_err,
  input logic              out_ecc_err,
  input logic              out_multi_err,
  input logic [DATA_W-1:0] out_data
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);  // R9
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(out_data) && $stable(out_check));  // R9
  AST_SYN_FORM: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_rd) |=> out_syndrome == (out_check ^ $past(in_ecc)));  // R2
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (out_syndrome == '0) |-> !out_data_err && !out_ecc_err && !out_multi_err);  // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    out_data_err |-> !out_ecc_err && !out_multi_err);  // R3
  AST_MULTI_WEIGHT: assert property (@(posedge clk) disable iff (!rst_q)
    out_multi_err |-> out_ecc_err && ($countones(out_syndrome) > 1));  // R6
  AST_FIX_ONE: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_rd) |=> out_data_err ==
      ($countones(out_data ^ $past(in_data)) == 1));  // R7
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !in_rd) |=> out_syndrome == '0 && !out_ecc_err &&
      out_data == $past(in_data));  // R8
endmodule

bind secded64_codec secded64_codec_chk u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .in_valid      (in_valid),
  .in_rd         (in_rd),
  .in_data       (in_data),
  .in_ecc        (in_ecc),
  .out_valid     (out_valid),
  .out_check     (out_check),
  .out_syndrome  (out_syndrome),
  .out_data_err  (out_data_err),
  .out_ecc_err   (out_ecc_err),
  .out_multi_err (out_multi_err),
  .out_data      (out_data)
);

// File: tb/tb_secded64_codec.sv
module tb_secded64_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_rd = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ecc = '0;
  logic        out_valid;
  logic [7:0]  out_check;
  logic [7:0]  out_syndrome;
  logic        out_data_err;
  logic [5:0]  out_data_idx;
  logic        out_ecc_err;
  logic [2:0]  out_ecc_idx;
  logic        out_multi_err;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected output state
  logic        e_valid = 0, e_derr = 0, e_eerr = 0, e_multi = 0;
  logic [7:0]  e_chk = 0, e_syn = 0;
  logic [5:0]  e_didx = 0;
  logic [2:0]  e_eidx = 0;
  logic [63:0] e_data = 0;

  always #10 clk = ~clk;

  secded64_codec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd),
    .in_data(in_data), .in_ecc(in_ecc), .out_valid(out_valid),
    .out_check(out_check), .out_syndrome(out_syndrome),
    .out_data_err(out_data_err), .out_data_idx(out_data_idx),
    .out_ecc_err(out_ecc_err), .out_ecc_idx(out_ecc_idx),
    .out_multi_err(out_multi_err), .out_data(out_data)
  );

  function automatic logic [63:0] mask_of(int r);
    logic [63:0] t [8] = '{64'hf00fe11e_c33c0ff7, 64'h00ff00ff_00fff0ff,
                           64'h0f0f0f0f_0f0fff00, 64'h11113333_7777000f,
                           64'h22224444_8888222f, 64'h44448888_ffff4441,
                           64'h8888ffff_11118882, 64'hffff1111_22221114};
    return t[r];
  endfunction

  function automatic logic [7:0] ref_chk(logic [63:0] d);
    logic [7:0] c = '0;
    for (int r = 0; r < 8; r++) begin
      int ones = 0;
      for (int b = 0; b < 64; b++) if (mask_of(r)[b] && d[b]) ones++;
      c[r] = ones[0];
    end
    return c;
  endfunction

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("R9 out_valid", 64'(out_valid), 64'(e_valid));
    cmp("R1 out_check", 64'(out_check), 64'(e_chk));
    cmp("R2 out_syndrome", 64'(out_syndrome), 64'(e_syn));
    cmp("R3 out_data_err", 64'(out_data_err), 64'(e_derr));
    cmp("R3 out_data_idx", 64'(out_data_idx), 64'(e_didx));
    cmp("R4 out_ecc_err", 64'(out_ecc_err), 64'(e_eerr));
    cmp("R4 out_ecc_idx", 64'(out_ecc_idx), 64'(e_eidx));
    cmp("R6 out_multi_err", 64'(out_multi_err), 64'(e_multi));
    cmp("R7 out_data", out_data, e_data);
  endtask

  // model: compute expected result of one request
  task automatic model(logic v, logic rd, logic [63:0] d, logic [7:0] ecc);
    e_valid = v;
    if (!v) return;
    e_chk  = ref_chk(d);
    e_syn  = rd ? (e_chk ^ ecc) : 8'h00;  // R8 write mode
    e_derr = 0; e_didx = 0; e_eerr = 0; e_eidx = 0; e_multi = 0;
    e_data = d;
    if (e_syn != 0) begin
      int found = -1;
      for (int k = 0; k < 64 && found < 0; k++) begin
        logic [7:0] col;
        for (int r = 0; r < 8; r++) col[r] = mask_of(r)[k];
        if (col == e_syn) found = k;
      end
      if (found >= 0) begin
        e_derr = 1; e_didx = 6'(found);
        e_data[found] = ~e_data[found];
      end else begin
        int lo = -1;
        int cnt = 0;
        for (int b = 7; b >= 0; b--) if (e_syn[b]) begin lo = b; cnt++; end
        e_eerr = 1; e_eidx = 3'(lo);
        e_multi = (cnt > 1);
      end
    end
  endtask

  // starts and ends at a falling edge
  task automatic step(logic v, logic rd, logic [63:0] d, logic [7:0] ecc);
    in_valid = v; in_rd = rd; in_data = d; in_ecc = ecc;
    @(posedge clk);
    model(v, rd, d, ecc);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    compare_all();  // R10 reset state: all zero
    rst_n = 1'b1;
    in_valid = 1'b1; in_data = 64'hffff_ffff_ffff_ffff;
    @(posedge clk); @(negedge clk);
    compare_all();  // R10 first edge after release still reset
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    // R1 R8 write mode encoding
    step(1, 0, 64'h0, 8'h00);
    step(1, 0, 64'hffff_ffff_ffff_ffff, 8'h5a);
    step(1, 0, 64'h0123_4567_89ab_cdef, 8'hff);
    // R9 hold while idle
    step(0, 1, 64'hdead_beef_0000_0001, 8'h11);
    step(0, 0, 64'h0, 8'h00);
    // R5 clean read
    d = 64'hcafe_f00d_1234_5678;
    step(1, 1, d, ref_chk(d));
    // R3 R7 every data bit
    for (int k = 0; k < 64; k++) begin
      d = {$urandom, $urandom};
      step(1, 1, d ^ (64'(1) << k), ref_chk(d));
    end
    // R4 each check bit
    for (int j = 0; j < 8; j++) begin
      d = {$urandom, $urandom};
      step(1, 1, d, ref_chk(d) ^ (8'(1) << j));
    end
    // R6 double and triple faults
    for (int n = 0; n < 40; n++) begin
      int a = $urandom_range(0, 71);
      int b = $urandom_range(0, 71);
      int c = $urandom_range(0, 71);
      logic [63:0] dd;
      logic [7:0] ee;
      d = {$urandom, $urandom};
      dd = d; ee = ref_chk(d);
      if (a < 64) dd[a] = ~dd[a]; else ee[a-64] = ~ee[a-64];
      if (b < 64) dd[b] = ~dd[b]; else ee[b-64] = ~ee[b-64];
      if (n[0] && c < 64) dd[c] = ~dd[c];
      step(1, 1, dd, ee);
    end
    // mixed random traffic including idle cycles
    for (int n = 0; n < 300; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           {$urandom, $urandom}, 8'($urandom));
    end
    finish_run();
  end
endmodule